// File: doc/BRIEF.md
# Low-Speed Serial Bus Packet Receiver

This block turns the differential line pair of a 1.5 Mbit/s USB low-speed link into a stream of byte writes. It runs from a system clock that is a fixed multiple of the bit rate, eight clocks per bit by default. The D+ and D- inputs are assumed to be synchronised to that clock already. While the line is idle (J: D- high, D+ low), the receiver waits for the first change to K. It then steps through the alternating sync bits. It locks only when two K bits arrive in a row, and from then on it samples near the middle of each bit.

Once locked, the block decodes NRZI against the D- level and drops the bit that follows every run of six ones. It assembles the payload least significant bit first. Each finished byte goes out on a one-cycle write strobe with its data and buffer index. A packet ends in one of three ways: a single-ended zero on the line, the byte budget being exceeded, or a failed sync hunt. Each of these ends with a one-cycle completion pulse that carries the byte count and two error flags. After the pulse, the receiver waits for the line to return to J before it hunts again.

Top module: `ls_usb_rx`

## Requirements
- R1: After reset, and after every completion pulse, the receiver ignores the line until it sees J (`dm_i`=1, `dp_i`=0). Only then does it look for K (`dm_i`=0, `dp_i`=1). Out of reset all outputs are 0.
- R2: A K first seen at clock edge t is checked again at edge t + CLKS_PER_BIT + CLKS_PER_BIT/2 - 1. If that sample is K, the receiver locks. Later samples follow every CLKS_PER_BIT clocks. The sync pattern on D- is 0,1,0,1,0,1,0,0 (K J K J K J K K).
- R3: If the check sample is not K, the receiver searches for the next K. If SYNC_TMO clocks pass without a K, it emits a completion pulse with the sync-error flag set, a length of 0 and no byte writes.
- R4: A data bit is 1 when the sampled D- level equals the previous sampled level, and 0 when it differs. The first reference level is the final sync K (D- = 0).
- R5: After six consecutive decoded ones, the next sample is dropped and does not advance the bit position. The final sync bit counts as the first one of a run.
- R6: Bits are packed least significant bit first. Each eighth bit produces a one-cycle `wr_en_o` carrying the byte on `wr_data_o`. `wr_addr_o` starts at 0 and rises by one for each byte in the packet.
- R7: A single-ended zero (both lines low) sampled at bit position 1 of a byte ends the packet. The completion pulse reports the number of whole bytes; a dribble bit at position 0 is discarded.
- R8: A single-ended zero sampled at bit position 0 does not end the packet. It is decoded as a D- low level.
- R9: When bit position 2 of byte number BUF_BYTES+1 is accepted, the packet is aborted. The completion pulse has the overflow flag set and a length of BUF_BYTES, and no write index ever reaches BUF_BYTES.
- R10: `wr_en_o` and `pkt_done_o` are single-cycle pulses. The two flags are low except during a completion pulse, and they are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLKS_PER_BIT per line bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | Synchronised D+ level |
| dm_i | input | 1 | Synchronised D- level |
| wr_en_o | output | 1 | Byte write strobe |
| wr_addr_o | output | AW | Byte index within the packet |
| wr_data_o | output | 8 | Received byte |
| pkt_done_o | output | 1 | Packet completion pulse |
| pkt_len_o | output | AW | Whole bytes received, valid with `pkt_done_o` |
| pkt_ovf_o | output | 1 | Byte budget exceeded, valid with `pkt_done_o` |
| pkt_serr_o | output | 1 | Sync hunt timed out, valid with `pkt_done_o` |

## Verification
The bench builds the receiver with eight clocks per bit, a budget of four bytes and a sixteen-clock sync timeout. With only four bytes of budget, the overflow abort, the full-buffer packet and the full-buffer packet with a dribble bit all fit in short packets. The bench also sweeps every single-byte value, which exercises stuffing after long runs of ones. The short timeout makes a lone K followed by idle finish quickly as a sync error. Multi-byte packets with moving patterns, a single-ended zero at bit 0 in the middle of a packet, and a long K before the first J cover the remaining orderings.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HUNT,
      ST_CHECK,
      ST_SEARCH,
      ST_RECV
   } rx_state_e;

   localparam int unsigned STUFF_RUN = 6;
   localparam int unsigned RUN_W     = $clog2(STUFF_RUN + 1);

endpackage

// File: rtl/lsrx_bit_timer.sv
module lsrx_bit_timer #(
   parameter int unsigned CLKS_PER_BIT = 8,
   parameter int unsigned SYNC_TMO     = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic stop_i,
   input  logic tmo_run_i,
   output logic smp_o,
   output logic tmo_o
);
   localparam int unsigned FIRST = CLKS_PER_BIT + CLKS_PER_BIT / 2 - 2;
   localparam int unsigned PW    = $clog2(FIRST + 1);
   localparam int unsigned TW    = $clog2(SYNC_TMO + 1);
   localparam logic [PW-1:0] FIRST_LD = PW'(FIRST);
   localparam logic [PW-1:0] BIT_LD   = PW'(CLKS_PER_BIT - 1);
   localparam logic [TW-1:0] TMO_LAST = TW'(SYNC_TMO - 1);

   logic          active;
   logic [PW-1:0] phase;
   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= '0;
      end else if (load_i) begin
         active <= 1'b1;
         phase  <= FIRST_LD;
      end else if (stop_i) begin
         active <= 1'b0;
         phase  <= '0;
      end else if (active) begin
         if (phase == '0) phase <= BIT_LD;
         else             phase <= phase - 1'b1;
      end
   end

   assign smp_o = active && (phase == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tcnt <= '0;
      else if (!tmo_run_i)       tcnt <= '0;
      else if (tcnt != TMO_LAST) tcnt <= tcnt + 1'b1;
   end

   assign tmo_o = tmo_run_i && (tcnt == TMO_LAST);

endmodule

// File: rtl/lsrx_nrzi.sv
module lsrx_nrzi
   import lsrx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic init_i,
   input  logic smp_i,
   input  logic lvl_i,
   output logic bit_vld_o,
   output logic bit_o
);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);

   logic             prev_lvl;
   logic [RUN_W-1:0] run;
   logic             stuffed;

   assign stuffed   = (run == RUN_MAX);
   assign bit_o     = (lvl_i == prev_lvl);
   assign bit_vld_o = smp_i && !stuffed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= 1'b1;
         run      <= '0;
      end else if (init_i) begin
         prev_lvl <= 1'b0;
         run      <= RUN_W'(1);
      end else if (smp_i) begin
         prev_lvl <= lvl_i;
         if (stuffed)    run <= '0;
         else if (bit_o) run <= run + 1'b1;
         else            run <= '0;
      end
   end

endmodule

// File: rtl/lsrx_pack.sv
module lsrx_pack #(
   parameter int unsigned BUF_BYTES = 11,
   parameter int unsigned AW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_i,
   input  logic          bit_vld_i,
   input  logic          bit_i,
   output logic [2:0]    idx_o,
   output logic [AW-1:0] cnt_o,
   output logic          ovf_o,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [7:0]    wr_data_o
);
   localparam logic [AW-1:0] BUDGET = AW'(BUF_BYTES);

   logic [7:0] lane;
   logic       take;

   assign ovf_o = bit_vld_i && (idx_o == 3'd2) && (cnt_o == BUDGET);
   assign take  = bit_vld_i && !ovf_o && !init_i;

   for (genvar g = 0; g < 8; g++) begin : g_lane
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= 1'b0;
         else if (init_i)                     q <= 1'b0;
         else if (take && idx_o == 3'(g))     q <= bit_i;
      end
      assign lane[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_o     <= '0;
         cnt_o     <= '0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (init_i) begin
            idx_o <= '0;
            cnt_o <= '0;
         end else if (take) begin
            if (idx_o == 3'd7) begin
               idx_o     <= '0;
               cnt_o     <= cnt_o + 1'b1;
               wr_en_o   <= 1'b1;
               wr_addr_o <= cnt_o;
               wr_data_o <= {bit_i, lane[6:0]};
            end else begin
               idx_o <= idx_o + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ls_usb_rx.sv
module ls_usb_rx
   import lsrx_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT = 8,
   parameter int unsigned BUF_BYTES    = 11,
   parameter int unsigned SYNC_TMO     = 16,
   localparam int unsigned AW          = $clog2(BUF_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dp_i,
   input  logic          dm_i,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [7:0]    wr_data_o,
   output logic          pkt_done_o,
   output logic [AW-1:0] pkt_len_o,
   output logic          pkt_ovf_o,
   output logic          pkt_serr_o
);
   if (CLKS_PER_BIT < 4 || (CLKS_PER_BIT % 2) != 0) begin : g_bad_cpb
      $error("CLKS_PER_BIT must be even and at least 4");
   end
   if (BUF_BYTES < 1) begin : g_bad_buf
      $error("BUF_BYTES must be at least 1");
   end
   if (SYNC_TMO < 2) begin : g_bad_tmo
      $error("SYNC_TMO must be at least 2");
   end

   rx_state_e     st;
   logic          is_j, is_k, is_se0;
   logic          smp, tmo;
   logic          load, stop, lock;
   logic          eop_now, ovf_now, sync_fail;
   logic          rx_smp, bit_vld, bit_val;
   logic [2:0]    idx;
   logic [AW-1:0] cnt;

   assign is_j   =  dm_i && !dp_i;
   assign is_k   = !dm_i &&  dp_i;
   assign is_se0 = !dm_i && !dp_i;

   assign load      = ((st == ST_HUNT) || (st == ST_SEARCH)) && is_k;
   assign lock      = (st == ST_CHECK) && smp && is_k;
   assign eop_now   = (st == ST_RECV) && smp && (idx == 3'd1) && is_se0;
   assign rx_smp    = (st == ST_RECV) && smp && !eop_now;
   assign sync_fail = (st == ST_SEARCH) && !is_k && tmo;
   assign stop      = ((st == ST_CHECK) && smp && !is_k) ||
                      ((st == ST_RECV) && (eop_now || ovf_now));

   lsrx_bit_timer #(
      .CLKS_PER_BIT(CLKS_PER_BIT),
      .SYNC_TMO    (SYNC_TMO)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .stop_i   (stop),
      .tmo_run_i(st == ST_SEARCH),
      .smp_o    (smp),
      .tmo_o    (tmo)
   );

   lsrx_nrzi u_nrzi (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_i   (lock),
      .smp_i    (rx_smp),
      .lvl_i    (dm_i),
      .bit_vld_o(bit_vld),
      .bit_o    (bit_val)
   );

   lsrx_pack #(
      .BUF_BYTES(BUF_BYTES),
      .AW       (AW)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_i   (lock),
      .bit_vld_i(bit_vld),
      .bit_i    (bit_val),
      .idx_o    (idx),
      .cnt_o    (cnt),
      .ovf_o    (ovf_now),
      .wr_en_o  (wr_en_o),
      .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
      end else begin
         case (st)
            ST_IDLE:   if (is_j) st <= ST_HUNT;
            ST_HUNT:   if (is_k) st <= ST_CHECK;
            ST_CHECK:  if (smp)  st <= is_k ? ST_RECV : ST_SEARCH;
            ST_SEARCH: begin
               if (is_k)     st <= ST_CHECK;
               else if (tmo) st <= ST_IDLE;
            end
            ST_RECV:   if (eop_now || ovf_now) st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_done_o <= 1'b0;
         pkt_len_o  <= '0;
         pkt_ovf_o  <= 1'b0;
         pkt_serr_o <= 1'b0;
      end else begin
         pkt_done_o <= eop_now || (st == ST_RECV && ovf_now) || sync_fail;
         pkt_len_o  <= (eop_now || (st == ST_RECV && ovf_now)) ? cnt : '0;
         pkt_ovf_o  <= (st == ST_RECV) && ovf_now;
         pkt_serr_o <= sync_fail;
      end
   end

endmodule

// File: rtl/ls_usb_rx_chk.sv
module ls_usb_rx_chk #(
   parameter int unsigned BUF_BYTES = 11,
   parameter int unsigned AW        = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en_o,
   input logic [AW-1:0] wr_addr_o,
   input logic          pkt_done_o,
   input logic [AW-1:0] pkt_len_o,
   input logic          pkt_ovf_o,
   input logic          pkt_serr_o
);
   p_serr_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done_o && pkt_serr_o) |-> (pkt_len_o == '0));

   p_no_wr_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_o && pkt_done_o));

   p_wr_in_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (int'(wr_addr_o) < int'(BUF_BYTES)));

   p_ovf_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done_o && pkt_ovf_o) |-> (int'(pkt_len_o) == int'(BUF_BYTES)));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done_o |=> !pkt_done_o);

   p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   p_flags_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_ovf_o || pkt_serr_o) |-> pkt_done_o);

   p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done_o |-> !(pkt_ovf_o && pkt_serr_o));

endmodule

bind ls_usb_rx ls_usb_rx_chk #(
   .BUF_BYTES(BUF_BYTES),
   .AW       (AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en_o   (wr_en_o),
   .wr_addr_o (wr_addr_o),
   .pkt_done_o(pkt_done_o),
   .pkt_len_o (pkt_len_o),
   .pkt_ovf_o (pkt_ovf_o),
   .pkt_serr_o(pkt_serr_o)
);

// File: tb/ls_usb_rx_test.sv
module ls_usb_rx_test;
   localparam int CPB = 8;
   localparam int BUF = 4;
   localparam int TMO = 16;
   localparam int AW  = $clog2(BUF + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dp = 1'b0;
   logic          dm = 1'b1;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;
   logic          pkt_done;
   logic [AW-1:0] pkt_len;
   logic          pkt_ovf;
   logic          pkt_serr;

   always #4 clk = ~clk;

   ls_usb_rx #(.CLKS_PER_BIT(CPB), .BUF_BYTES(BUF), .SYNC_TMO(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .pkt_done_o(pkt_done), .pkt_len_o(pkt_len),
      .pkt_ovf_o(pkt_ovf), .pkt_serr_o(pkt_serr)
   );

   int n_chk = 0;
   int n_err = 0;

   int   wr_n = 0;
   int   done_n = 0;
   int   cap_a [0:31];
   int   cap_d [0:31];
   int   g_len, g_ovf, g_serr;

   logic [7:0] pk [0:15];
   logic       lv_m [0:2047];
   logic       lv_p [0:2047];
   int         bstart [0:15];
   int         nlv;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            if (wr_n < 32) begin
               cap_a[wr_n] = int'(wr_addr);
               cap_d[wr_n] = int'(wr_data);
            end
            wr_n++;
         end
         if (pkt_done) begin
            if (done_n == 0) begin
               g_len  = int'(pkt_len);
               g_ovf  = int'(pkt_ovf);
               g_serr = int'(pkt_serr);
            end
            done_n++;
         end
      end
   end

   task automatic check_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push_lvl(input logic m, input logic p);
      lv_m[nlv] = m;
      lv_p[nlv] = p;
      nlv++;
   endtask

   task automatic hold(input logic m, input logic p, input int nbits);
      dm = m;
      dp = p;
      repeat (nbits * CPB) @(negedge clk);
   endtask

   // Encoder: sync, NRZI on D-, stuffing after six ones (last sync bit counts).
   task automatic build(input int n, input bit drib);
      logic cur;
      int   ones;
      nlv = 0;
      for (int i = 0; i < 8; i++) begin
         if (i == 7 || (i % 2) == 0) push_lvl(1'b0, 1'b1);
         else                        push_lvl(1'b1, 1'b0);
      end
      cur  = 1'b0;
      ones = 1;
      for (int b = 0; b < n; b++) begin
         bstart[b] = nlv;
         for (int i = 0; i < 8; i++) begin
            if (pk[b][i]) ones++;
            else begin
               cur  = ~cur;
               ones = 0;
            end
            push_lvl(cur, ~cur);
            if (ones == 6) begin
               cur  = ~cur;
               ones = 0;
               push_lvl(cur, ~cur);
            end
         end
      end
      if (drib) push_lvl(cur, ~cur);
      push_lvl(1'b0, 1'b0);
      push_lvl(1'b0, 1'b0);
      push_lvl(1'b1, 1'b0);
      push_lvl(1'b1, 1'b0);
   endtask

   task automatic run_pkt(input int n, input bit drib, input int exp_len,
                          input bit exp_ovf, input int glitch_byte);
      build(n, drib);
      if (glitch_byte >= 0) begin
         check_eq("R8 glitch position carries D- low", int'(lv_m[bstart[glitch_byte]]), 0);
         lv_p[bstart[glitch_byte]] = 1'b0;
      end
      wr_n   = 0;
      done_n = 0;
      hold(1'b1, 1'b0, 3);
      for (int k = 0; k < nlv; k++) begin
         dm = lv_m[k];
         dp = lv_p[k];
         repeat (CPB) @(negedge clk);
      end
      hold(1'b1, 1'b0, 5);
      check_eq("R7 completion pulse seen", (done_n > 0) ? 1 : 0, 1);
      check_eq("R7 packet length", g_len, exp_len);
      check_eq("R9 overflow flag", g_ovf, int'(exp_ovf));
      check_eq("R3 no sync error on good sync", g_serr, 0);
      check_eq("R9 write count", wr_n, exp_len);
      for (int i = 0; i < exp_len && i < 32; i++) begin
         check_eq("R6 write index", cap_a[i], i);
         check_eq("R4 R5 R6 byte value", cap_d[i], int'(pk[i]));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check_eq("R1 reset wr_en", int'(wr_en), 0);
      check_eq("R1 reset pkt_done", int'(pkt_done), 0);
      check_eq("R1 reset pkt_len", int'(pkt_len), 0);
      check_eq("R1 reset flags", int'(pkt_ovf) + int'(pkt_serr), 0);
      rst_n = 1'b1;

      // R1: line starts in K after reset; must not lock before a J.
      wr_n   = 0;
      done_n = 0;
      hold(1'b0, 1'b1, 4);
      check_eq("R1 no activity before J", wr_n + done_n, 0);
      hold(1'b1, 1'b0, 4);
      pk[0] = 8'hA5;
      pk[1] = 8'h3C;
      run_pkt(2, 1'b0, 2, 1'b0, -1);

      // R4 R5 R6: every single-byte value
      for (int v = 0; v < 256; v++) begin
         pk[0] = 8'(v);
         run_pkt(1, 1'b0, 1, 1'b0, -1);
      end

      // R7: empty packet and lengths up to the budget
      for (int len = 0; len <= BUF; len++) begin
         for (int i = 0; i < len; i++) pk[i] = 8'((len * 37 + i * 91) ^ 8'h5A);
         run_pkt(len, 1'b0, len, 1'b0, -1);
      end

      // R5: long runs of ones across byte boundaries
      for (int i = 0; i < BUF; i++) pk[i] = 8'hFF;
      run_pkt(BUF, 1'b0, BUF, 1'b0, -1);
      pk[0] = 8'h7F; pk[1] = 8'hFE; pk[2] = 8'hFC; pk[3] = 8'h3F;
      run_pkt(4, 1'b0, 4, 1'b0, -1);

      // R7: dribble bit before end of packet
      pk[0] = 8'h00; pk[1] = 8'h12;
      run_pkt(2, 1'b1, 2, 1'b0, -1);

      // R9 boundary: full budget plus dribble bit is not an overflow
      for (int i = 0; i < BUF; i++) pk[i] = 8'h00;
      run_pkt(BUF, 1'b1, BUF, 1'b0, -1);

      // R8: single-ended zero at bit 0 of byte 1 mid-packet
      pk[0] = 8'h00; pk[1] = 8'h35; pk[2] = 8'hA7;
      run_pkt(3, 1'b0, 3, 1'b0, 1);

      // R9: overflow on byte BUF+1
      pk[0] = 8'hC3; pk[1] = 8'h5A; pk[2] = 8'hFF; pk[3] = 8'h01;
      pk[4] = 8'h00; pk[5] = 8'h00;
      run_pkt(6, 1'b0, BUF, 1'b1, -1);

      // R2 R3: lone K then idle gives a sync error
      wr_n   = 0;
      done_n = 0;
      hold(1'b1, 1'b0, 3);
      hold(1'b0, 1'b1, 1);
      hold(1'b1, 1'b0, 6);
      check_eq("R3 sync error pulse", (done_n > 0) ? 1 : 0, 1);
      check_eq("R3 sync error flag", g_serr, 1);
      check_eq("R3 sync error length", g_len, 0);
      check_eq("R3 sync error overflow flag", g_ovf, 0);
      check_eq("R3 no writes on sync error", wr_n, 0);

      // R2: K K lock right after a sync error
      pk[0] = 8'h81; pk[1] = 8'h42; pk[2] = 8'h24;
      run_pkt(3, 1'b0, 3, 1'b0, -1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule